// File: doc/BRIEF.md
# Variable-Latency Speculative Adder

This block adds two WIDTH-bit operands and a carry-in. It splits the addition into a lower segment of SPLIT bits and an upper segment of the remaining bits, and both segment sums are formed in the same cycle. The upper segment does not wait for the true carry out of the lower segment. It uses an estimated carry instead: the carry out of a narrow EST_BITS-wide sum over the most significant lower-segment bits, taken with a zero carry-in. This keeps the critical path to one segment plus the small estimator.

A detector compares the estimate with the real lower-segment carry-out in the same cycle. When they agree, the result is presented one cycle after acceptance. When they differ, the block spends one more cycle adding one to the registered upper sum. While it does so it holds off the requester, and it marks the result as slow.

The controller has two states. In `ST_IDLE` the block is ready and accepts requests. The transition *accept-hit* stays in `ST_IDLE`. The transition *accept-miss* moves to `ST_RECOVER`. In `ST_RECOVER` the block is not ready. The transition *repair-done* always returns to `ST_IDLE` after one cycle and presents the corrected result.

Top module: `vlsa_adder`

## Requirements
- R1: During reset and in the first cycle after it, in_ready is 1, out_valid is 0 and out_slow is 0.
- R2: In ST_IDLE in_ready is 1. A request is accepted at a rising edge where in_valid and in_ready are both 1.
- R3: If the estimated carry equals the true lower-segment carry, out_valid is 1 with out_slow 0 in the cycle right after acceptance. out_sum then equals bits WIDTH-1..0 of a+b+cin.
- R4: The estimate is the carry out of adding a[SPLIT-1:SPLIT-EST_BITS] and b[SPLIT-1:SPLIT-EST_BITS] with carry-in 0. The true carry is bit SPLIT of a[SPLIT-1:0]+b[SPLIT-1:0]+cin. A result is slow exactly when the true carry is 1 and the estimate is 0.
- R5: A slow result is presented two cycles after acceptance, with out_valid 1, out_slow 1 and the correct full sum.
- R6: For the cycle after a slow acceptance (ST_RECOVER), in_ready is 0 and any in_valid in that cycle is ignored: no request is accepted and no extra result appears.
- R7: With every valid result, out_cout equals bit WIDTH of a+b+cin.
- R8: The estimate is never 1 while the true lower-segment carry is 0.
- R9: out_valid is a one-cycle pulse, exactly one per accepted request. out_slow is 0 whenever out_valid is 0.
- R10: A new request can be accepted in the same cycle as the previous result is presented, so fast requests run back to back at one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request (ST_IDLE) |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| in_cin | input | 1 | Carry-in |
| out_valid | output | 1 | Result present this cycle |
| out_sum | output | WIDTH | Sum bits |
| out_cout | output | 1 | Full-width carry-out |
| out_slow | output | 1 | Result needed the repair cycle |

## Verification
The patterns separate the three carry situations at the split:
- no lower carry at all;
- a carry that the window itself generates, which the estimate catches and which must stay fast;
- a carry that ripples up from below the window or from cin, which must go slow.

Operands built as b = ~a in the lower half with cin set force the long-ripple case. All-ones operands check the carry-out. Requests held on in_valid through a repair cycle show that the stalled request is dropped rather than taken twice. Back-to-back fast requests show the one-per-cycle rate, and random operands cover the mix.

// File: rtl/vlsa_pkg.sv
package vlsa_pkg;
    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_RECOVER = 1'b1
    } vlsa_state_e;
endpackage

// File: rtl/vlsa_seg_add.sv
// Plain ripple-style segment adder with carry in and carry out.
module vlsa_seg_add #(
    parameter int N = 16
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         c_i,
    output logic [N-1:0] s_o,
    output logic         c_o
);
    localparam int EW = N + 1;
    logic [EW-1:0] total;

    assign total = {1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, c_i};
    assign s_o   = total[N-1:0];
    assign c_o   = total[N];
endmodule

// File: rtl/vlsa_carry_est.sv
// Carry out of the top window of the lower segment, carry-in taken as 0.
module vlsa_carry_est #(
    parameter int EST_BITS = 4
) (
    input  logic [EST_BITS-1:0] wa_i,
    input  logic [EST_BITS-1:0] wb_i,
    output logic                est_o
);
    logic [EST_BITS:0] chain;

    assign chain[0] = 1'b0;
    for (genvar i = 0; i < EST_BITS; i++) begin : g_bit
        logic gen_b, prop_b;
        assign gen_b       = wa_i[i] & wb_i[i];
        assign prop_b      = wa_i[i] ^ wb_i[i];
        assign chain[i+1]  = gen_b | (prop_b & chain[i]);
    end
    assign est_o = chain[EST_BITS];
endmodule

// File: rtl/vlsa_ctrl.sv
module vlsa_ctrl
    import vlsa_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic miss_i,
    output logic ready_o,
    output logic accept_o,
    output logic repair_o,
    output logic valid_o,
    output logic slow_o
);
    vlsa_state_e state_q, state_d;

    assign ready_o  = (state_q == ST_IDLE);
    assign accept_o = req_i & ready_o;
    assign repair_o = (state_q == ST_RECOVER);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept_o && miss_i) state_d = ST_RECOVER;
            ST_RECOVER: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            valid_o <= 1'b0;
            slow_o  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    valid_o <= accept_o & ~miss_i;
                    slow_o  <= 1'b0;
                end
                ST_RECOVER: begin
                    valid_o <= 1'b1;
                    slow_o  <= 1'b1;
                end
                default: begin
                    valid_o <= 1'b0;
                    slow_o  <= 1'b0;
                end
            endcase
        end
    end

    // R6
    stall_after_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept_o && miss_i) |=> !ready_o);
    // R3
    fast_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept_o && !miss_i) |=> (valid_o && !slow_o));
    // R5
    slow_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ready_o |=> (valid_o && slow_o && ready_o));
    // R9
    valid_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> ($past(accept_o) || $past(repair_o)));
    // R9
    slow_only_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slow_o |-> valid_o);
endmodule

// File: rtl/vlsa_adder.sv
module vlsa_adder #(
    parameter int WIDTH    = 32,
    parameter int SPLIT    = 16,
    parameter int EST_BITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             in_cin,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_sum,
    output logic             out_cout,
    output logic             out_slow
);
    localparam int UPPER = WIDTH - SPLIT;
    localparam int WLSB  = SPLIT - EST_BITS;
    localparam int HW    = UPPER + 1;

    logic [SPLIT-1:0] lo_sum;
    logic             lo_c;
    logic [UPPER-1:0] hi_sum;
    logic             hi_c;
    logic             est_c;
    logic             miss;
    logic             accept, repair;

    logic [SPLIT-1:0] lo_q;
    logic [HW-1:0]    hi_q;

    vlsa_seg_add #(.N(SPLIT)) u_lo (
        .a_i (in_a[SPLIT-1:0]),
        .b_i (in_b[SPLIT-1:0]),
        .c_i (in_cin),
        .s_o (lo_sum),
        .c_o (lo_c)
    );

    vlsa_carry_est #(.EST_BITS(EST_BITS)) u_est (
        .wa_i  (in_a[SPLIT-1:WLSB]),
        .wb_i  (in_b[SPLIT-1:WLSB]),
        .est_o (est_c)
    );

    vlsa_seg_add #(.N(UPPER)) u_hi (
        .a_i (in_a[WIDTH-1:SPLIT]),
        .b_i (in_b[WIDTH-1:SPLIT]),
        .c_i (est_c),
        .s_o (hi_sum),
        .c_o (hi_c)
    );

    assign miss = lo_c ^ est_c;

    vlsa_ctrl u_ctrl (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .req_i    (in_valid),
        .miss_i   (miss),
        .ready_o  (in_ready),
        .accept_o (accept),
        .repair_o (repair),
        .valid_o  (out_valid),
        .slow_o   (out_slow)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (accept) begin
            lo_q <= lo_sum;
            hi_q <= {hi_c, hi_sum};
        end else if (repair) begin
            hi_q <= hi_q + {{UPPER{1'b0}}, 1'b1};
        end
    end

    assign out_sum  = {hi_q[UPPER-1:0], lo_q};
    assign out_cout = hi_q[UPPER];

    // R8
    no_overstate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        est_c |-> lo_c);
    // R5
    repair_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> ({out_cout, out_sum[WIDTH-1:SPLIT]} ==
                       $past({out_cout, out_sum[WIDTH-1:SPLIT]}) + {{UPPER{1'b0}}, 1'b1}));
    // R5
    lower_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> $stable(out_sum[SPLIT-1:0]));
endmodule

// File: tb/tb_vlsa_adder.sv
`timescale 1ns/1ps
module tb_vlsa_adder;
    localparam int W = 32;
    localparam int S = 16;
    localparam int E = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         in_cin = 1'b0;
    logic         out_valid;
    logic [W-1:0] out_sum;
    logic         out_cout;
    logic         out_slow;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // behavioural model state
    bit          m_busy = 1'b0;
    logic [W:0]  m_held = '0;
    bit          ev = 1'b0;
    bit          es = 1'b0;
    logic [W:0]  esum = '0;

    always #2.5 clk = ~clk;

    vlsa_adder #(.WIDTH(W), .SPLIT(S), .EST_BITS(E)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_cin(in_cin), .out_valid(out_valid),
        .out_sum(out_sum), .out_cout(out_cout), .out_slow(out_slow)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock of stimulus, entered and left at a falling edge
    task automatic step(bit v, logic [W-1:0] a, logic [W-1:0] b, bit c);
        logic [W:0]   full;
        logic [S:0]   lo_t;
        logic [E:0]   win_t;
        bit           acc, miss;
        in_valid = v; in_a = a; in_b = b; in_cin = c;
        chk(m_busy ? "R6 in_ready" : "R2 in_ready", 64'(in_ready), 64'(!m_busy));
        acc   = v && !m_busy;
        full  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
        lo_t  = {1'b0, a[S-1:0]} + {1'b0, b[S-1:0]} + {{S{1'b0}}, c};
        win_t = {1'b0, a[S-1:S-E]} + {1'b0, b[S-1:S-E]};
        miss  = lo_t[S] && !win_t[E];
        @(posedge clk);
        if (m_busy) begin
            ev = 1; es = 1; esum = m_held; m_busy = 0;
        end else if (acc && miss) begin
            ev = 0; es = 0; m_busy = 1; m_held = full;
        end else if (acc) begin
            ev = 1; es = 0; esum = full;
        end else begin
            ev = 0; es = 0;
        end
        @(negedge clk);
        chk("R9 out_valid", 64'(out_valid), 64'(ev));
        chk("R4,R8 out_slow", 64'(out_slow), 64'(es));
        if (ev) begin
            chk(es ? "R5 out_sum" : "R3 out_sum", 64'(out_sum), 64'(esum[W-1:0]));
            chk("R7 out_cout", 64'(out_cout), 64'(esum[W]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 in_ready", 64'(in_ready), 64'd1);
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 out_slow", 64'(out_slow), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after", 64'(out_valid), 64'd0);

        // no lower carry: fast
        step(1, 32'h0000_0000, 32'h0000_0000, 0);
        step(1, 32'h1234_0123, 32'h0001_0456, 0);
        // carry generated inside window: estimate hits (R4, fast)
        step(1, 32'h0000_F000, 32'h0000_1000, 0);
        // carry from below window: slow (R4, R5)
        step(1, 32'h0000_FFFF, 32'h0000_0001, 0);
        step(0, '0, '0, 0);
        // carry-in rippling all the way: slow
        step(1, 32'hABCD_FFFF, 32'h0000_0000, 1);
        step(0, '0, '0, 0);
        // all ones, full carry-out (R7)
        step(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
        step(1, 32'hFFFF_0000, 32'h0001_0000, 0);
        // R6: request held through the repair cycle is dropped
        step(1, 32'h0000_8FFF, 32'h0000_7001, 0);
        step(1, 32'h1111_1111, 32'h2222_2222, 0);
        step(1, 32'h1111_1111, 32'h2222_2222, 0);
        // R10: back-to-back fast requests
        for (int i = 0; i < 8; i++) step(1, 32'(i * 32'h0101_0101), 32'(i), 0);
        step(0, '0, '0, 0);
        // random mix, with a biased long-ripple share
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] ra, rb;
            bit rc, rv;
            ra = $urandom; rb = $urandom; rc = 1'($urandom);
            rv = ($urandom % 4) != 0;
            if (($urandom % 3) == 0) begin
                rb[S-1:0] = ~ra[S-1:0]; rc = 1'b1;
            end
            step(rv, ra, rb, rc);
        end
        step(0, '0, '0, 0);
        step(0, '0, '0, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule